// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synchronous model of a byte-wide serial EEPROM that answers on a two-wire (I2C-style) bus. The system clock samples SCL and SDA. The block detects START and STOP conditions and shifts bytes in and out. It acknowledges a byte by pulling SDA low, which is modelled as an output enable for an external open-drain pad. The first byte after a START holds a fixed device type, three bits that must equal the strap inputs, and a direction bit. A write then carries a two-byte word address, high byte first, followed by optional data bytes.

Data bytes collect in a page buffer. The write to the array happens during a self-timed busy period that starts at the STOP ending the sequence. While that period runs, the slave refuses its own device address, so a master can poll until the write is finished.

Reads return bytes from an internal counter that steps through the whole array. This supports three forms of read:
- a current-address read;
- a random read, which is a dummy write of the address, a repeated START and a read;
- a sequential read that continues for as long as the master acknowledges.

A write-protect input guards the whole array. The array depth, the page size and the busy duration are parameters, so a simulation can use a small memory and a short write cycle.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset the slave does not drive SDA (sdaOe low), is not busy, and acknowledges its device address at once.
- R2: The slave responds only to a first byte of the form {1010, strap[2:0], rw} (MSB first, rw=0 write, rw=1 read). For any other value it leaves SDA released through that byte's ninth clock and all later clocks until the next START.
- R3: The slave acknowledges each accepted byte (device address, both word address bytes, write data) by holding SDA low for the whole high phase of the ninth SCL clock.
- R4: The word address is two bytes, high byte first. Only its low ADDR_W bits select a location, so addresses that differ only above bit ADDR_W-1 name the same byte. A byte written this way reads back through a random read.
- R5: A single write may carry up to 2^PAGE_W (128) data bytes. Each byte advances only the low PAGE_W address bits, wrapping within the page, and bytes outside the written offsets keep their old values.
- R6: If wrProtect is high at the STOP that ends a write, the array keeps its contents and no busy period starts.
- R7: A STOP that ends a write with at least one data byte starts a busy period of WR_CYCLES clocks. During that period the device address is not acknowledged. Once the period ends, the address is acknowledged again and the new data reads back.
- R8: A read returns successive bytes while the master acknowledges each one. The address steps across the whole array and wraps from the last byte to 0. A master NACK followed by STOP ends the read.
- R9: A read with no preceding address returns the byte that follows the last byte read.
- R10: If a START arrives before the STOP of a write, the data bytes already sent are discarded: memory is unchanged and no busy period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock level seen on the bus |
| sdaIn | input | 1 | Serial data level seen on the bus |
| strap | input | 3 | Address straps compared with the device address byte |
| wrProtect | input | 1 | High protects the whole array from writes |
| sdaOe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench writes a page that starts eight bytes before the page boundary. A design that carried into the upper address bits would corrupt the next page instead of wrapping to offset 0. The bench polls straight after a STOP to confirm the busy refusal; a slave that answered at once would let the master read stale data. A sequential read crosses the top of the array and must come back to address 0, and a read with no address must continue from the counter that read left behind. Two further cases must leave memory untouched: a protected write, and a write cut short by a START. A design that committed the page buffer too eagerly would change memory in these cases or report itself busy.

// File: rtl/twe_pkg.sv
package twe_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_AHI, S_ALO, S_WDAT, S_ACK, S_RDAT, S_RACK
  } twe_state_e;

  // Strobes from the protocol control to the datapath
  typedef struct packed {
    logic shiftIn;
    logic clearBuf;
    logic setHi;
    logic setLo;
    logic storeByte;
    logic loadRead;
    logic shiftOut;
    logic commit;
  } twe_strobe_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/twe_ctrl.sv
module twe_ctrl
  import twe_pkg::*;
#(
  parameter int WR_CYCLES = 625000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strap,
  input  logic        wrProtect,
  input  logic [7:0]  rxByte,
  input  logic        txMsb,
  output twe_strobe_t st,
  output logic        dataBit,
  output logic        sdaOe
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic sclQ, sdaQ, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet, byteDone, devMatch, recvState;
  twe_state_e state, nextSt;
  logic [3:0] bitCnt;
  logic ackDrive, mAck, wrPending, busy;
  logic [CNT_W-1:0] busyCnt;

  assign sclRise   = sclQ && !sclPrev;
  assign sclFall   = !sclQ && sclPrev;
  assign startDet  = sclQ && sclPrev && sdaPrev && !sdaQ;
  assign stopDet   = sclQ && sclPrev && !sdaPrev && sdaQ;
  assign byteDone  = sclFall && (bitCnt == 4'd8);
  assign devMatch  = (rxByte[7:1] == {DEV_TYPE, strap}) && !busy;
  assign recvState = (state == S_DEV) || (state == S_AHI) ||
                     (state == S_ALO) || (state == S_WDAT);
  assign dataBit   = sdaQ;
  assign sdaOe     = ackDrive || ((state == S_RDAT) && !txMsb);

  always_comb begin
    st           = '0;
    st.shiftIn   = sclRise && recvState;
    st.clearBuf  = (state == S_DEV) && byteDone && devMatch && !rxByte[0];
    st.setHi     = (state == S_AHI) && byteDone;
    st.setLo     = (state == S_ALO) && byteDone;
    st.storeByte = (state == S_WDAT) && byteDone;
    st.loadRead  = sclFall && (((state == S_ACK) && (nextSt == S_RDAT)) ||
                               ((state == S_RACK) && mAck));
    st.shiftOut  = (state == S_RDAT) && sclFall && (bitCnt != 4'd8);
    st.commit    = stopDet && wrPending && !wrProtect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= 1'b1; sdaQ <= 1'b1; sclPrev <= 1'b1; sdaPrev <= 1'b1;
      state <= S_IDLE; nextSt <= S_IDLE; bitCnt <= '0;
      ackDrive <= 1'b0; mAck <= 1'b0; wrPending <= 1'b0;
      busy <= 1'b0; busyCnt <= '0;
    end else begin
      sclQ <= sclIn; sdaQ <= sdaIn; sclPrev <= sclQ; sdaPrev <= sdaQ;

      if (st.commit) begin
        busy    <= 1'b1;
        busyCnt <= CNT_W'(WR_CYCLES - 1);
      end else if (busy) begin
        if (busyCnt == '0) busy <= 1'b0;
        else busyCnt <= busyCnt - CNT_W'(1);
      end

      if (startDet) begin
        state <= S_DEV; bitCnt <= '0; ackDrive <= 1'b0; wrPending <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE; ackDrive <= 1'b0; wrPending <= 1'b0;
      end else begin
        unique case (state)
          S_DEV, S_AHI, S_ALO, S_WDAT: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            if (byteDone) begin
              bitCnt <= '0;
              if (state == S_DEV) begin
                if (devMatch) begin
                  ackDrive <= 1'b1;
                  state    <= S_ACK;
                  nextSt   <= rxByte[0] ? S_RDAT : S_AHI;
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                ackDrive <= 1'b1;
                state    <= S_ACK;
                if (state == S_AHI)      nextSt <= S_ALO;
                else                     nextSt <= S_WDAT;
                if (state == S_WDAT) wrPending <= 1'b1;
              end
            end
          end
          S_ACK: if (sclFall) begin
            ackDrive <= 1'b0;
            state    <= nextSt;
          end
          S_RDAT: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            if (sclFall && (bitCnt == 4'd8)) begin
              state  <= S_RACK;
              bitCnt <= '0;
            end
          end
          S_RACK: begin
            if (sclRise) mAck <= !sdaQ;
            if (sclFall) state <= mAck ? S_RDAT : S_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a device address seen while busy is never acknowledged
  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_DEV) && byteDone && busy) |=> !ackDrive);

  // R3: the acknowledge is only applied while SCL is low
  p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> !sclQ);

  // R6: a protected STOP never starts the write cycle
  p_wp_noop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && wrProtect && !busy) |=> !busy);

  // R2: an idle slave leaves SDA released
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaOe);

endmodule

// File: rtl/twe_datapath.sv
module twe_datapath
  import twe_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  twe_strobe_t st,
  input  logic        dataBit,
  output logic [7:0]  rxByte,
  output logic        txMsb
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int UP_W  = ADDR_W - PAGE_W;

  logic [7:0]        rxReg, txReg, hiReg;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   pageVld;
  logic              draining;
  logic [PAGE_W-1:0] drainIdx;
  logic [UP_W-1:0]   drainPage;
  logic [7:0]        mem [DEPTH];

  assign rxByte = rxReg;
  assign txMsb  = txReg[7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0; txReg <= 8'hFF; hiReg <= '0; addr <= '0;
      pageVld <= '0; draining <= 1'b0; drainIdx <= '0; drainPage <= '0;
    end else begin
      if (st.shiftIn)  rxReg <= {rxReg[6:0], dataBit};
      if (st.setHi)    hiReg <= rxReg;
      if (st.setLo)    addr  <= ADDR_W'({hiReg, rxReg});
      if (st.clearBuf) pageVld <= '0;
      if (st.storeByte) begin
        pageVld[addr[PAGE_W-1:0]] <= 1'b1;
        addr[PAGE_W-1:0]          <= addr[PAGE_W-1:0] + PAGE_W'(1);
      end
      if (st.loadRead) begin
        txReg <= mem[addr];
        addr  <= addr + ADDR_W'(1);
      end else if (st.shiftOut) begin
        txReg <= {txReg[6:0], 1'b1};
      end
      if (st.commit) begin
        draining  <= 1'b1;
        drainIdx  <= '0;
        drainPage <= addr[ADDR_W-1:PAGE_W];
      end else if (draining) begin
        drainIdx <= drainIdx + PAGE_W'(1);
        if (drainIdx == PAGE_W'(PAGE - 1)) draining <= 1'b0;
      end
    end
  end

  // Storage without reset: page buffer fill and one-byte-per-cycle drain
  always_ff @(posedge clk) begin
    if (st.storeByte) pageBuf[addr[PAGE_W-1:0]] <= rxReg;
    if (draining && pageVld[drainIdx]) mem[{drainPage, drainIdx}] <= pageBuf[drainIdx];
  end

  // R5: a stored data byte never moves the page number
  p_page_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.storeByte |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W])));

  // R8: each byte handed to the bus advances the counter by one, full-width wrap
  p_read_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.loadRead |=> (addr == $past(addr) + ADDR_W'(1)));

endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
  import twe_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 7,
  parameter int WR_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] strap,
  input  logic       wrProtect,
  output logic       sdaOe
);
  twe_strobe_t st;
  logic [7:0]  rxByte;
  logic        txMsb, dataBit;

  twe_ctrl #(.WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .wrProtect(wrProtect), .rxByte(rxByte), .txMsb(txMsb), .st(st),
    .dataBit(dataBit), .sdaOe(sdaOe)
  );

  twe_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .dataBit(dataBit),
    .rxByte(rxByte), .txMsb(txMsb)
  );

endmodule

// File: tb/tb_twowire_eeprom.sv
module tb_twowire_eeprom;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};
  localparam int NVEC = 6;
  // {word address, data}: byte write then random read-back
  localparam logic [23:0] VEC [NVEC] = '{24'h0000_11, 24'h0005_22, 24'h0080_33,
                                         24'h0010_44, 24'h017F_55, 24'h03FF_66};

  logic clk = 1'b0, rstN = 1'b0, mScl = 1'b1, mSda = 1'b1, wrProtect = 1'b0;
  logic sdaOe, sdaBus;
  int   nChecks = 0, nFail = 0;

  always #4 clk = ~clk;
  assign sdaBus = mSda & ~sdaOe;

  twowire_eeprom #(.ADDR_W(10), .PAGE_W(7), .WR_CYCLES(400)) dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .strap(STRAP),
    .wrProtect(wrProtect), .sdaOe(sdaOe)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (4) @(negedge clk); endtask

  task automatic busStart();
    mSda = 1'b1; hp(); mScl = 1'b1; hp(); mSda = 1'b0; hp(); mScl = 1'b0; hp();
  endtask

  task automatic busStop();
    mSda = 1'b0; hp(); mScl = 1'b1; hp(); mSda = 1'b1; hp();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; hp(); mScl = 1'b1; hp(); mScl = 1'b0;
    end
    mSda = 1'b1; hp(); mScl = 1'b1; hp(); ack = !sdaBus; mScl = 1'b0; hp();
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ack);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp(); mScl = 1'b1; hp(); b[i] = sdaBus; mScl = 1'b0;
    end
    mSda = ack ? 1'b0 : 1'b1; hp(); mScl = 1'b1; hp(); mScl = 1'b0; hp(); mSda = 1'b1;
  endtask

  task automatic wrSeq(input logic [15:0] a, input int n, input logic [7:0] seed,
                       output logic allAck);
    logic k;
    busStart();
    sendByte(DEV_W, k);      allAck = k;
    sendByte(a[15:8], k);    allAck &= k;
    sendByte(a[7:0], k);     allAck &= k;
    for (int j = 0; j < n; j++) begin
      sendByte(seed + 8'(j), k); allAck &= k;
    end
    busStop();
  endtask

  task automatic probe(output logic ack);
    busStart(); sendByte(DEV_W, ack); busStop();
  endtask

  task automatic waitReady(output int polls);
    logic k;
    polls = 0;
    do begin probe(k); polls++; end while (!k && polls < 50);
  endtask

  task automatic rdRand(input logic [15:0] a, output logic [7:0] d);
    logic k;
    busStart(); sendByte(DEV_W, k); sendByte(a[15:8], k); sendByte(a[7:0], k);
    busStart(); sendByte(DEV_R, k); recvByte(d, 1'b0); busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic k, allAck;
    logic [7:0] d;
    int polls;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: released bus and immediate response after reset
    chk("R1 sdaOe after reset", int'(sdaOe), 0);
    probe(k);
    chk("R1 ack right after reset", int'(k), 1);

    // R2: wrong strap value is ignored, including the following byte
    busStart();
    sendByte({4'b1010, 3'b000, 1'b0}, k);
    chk("R2 foreign address nack", int'(k), 0);
    sendByte(8'h00, k);
    chk("R2 later byte nack", int'(k), 0);
    busStop();

    // R4 / R3: vector table of byte writes and random reads
    for (int v = 0; v < NVEC; v++) begin
      wrSeq(VEC[v][23:8], 1, VEC[v][7:0], allAck);
      chk("R3 byte write acks", int'(allAck), 1);
      waitReady(polls);
      rdRand(VEC[v][23:8], d);
      chk("R4 read back", int'(d), int'(VEC[v][7:0]));
    end

    // R7: busy refusal then completion
    wrSeq(16'h0020, 1, 8'h5A, allAck);
    probe(k);
    chk("R7 nack while busy", int'(k), 0);
    waitReady(polls);
    chk("R7 ready before poll limit", int'(polls < 50), 1);
    rdRand(16'h0020, d);
    chk("R7 data after busy", int'(d), 8'h5A);

    // R4: address bits above ADDR_W alias
    wrSeq(16'h0403, 1, 8'h77, allAck);
    waitReady(polls);
    rdRand(16'h0003, d);
    chk("R4 alias read", int'(d), 8'h77);

    // R5: 12 bytes from offset 120 wrap inside page 0
    wrSeq(16'h0078, 12, 8'hA0, allAck);
    chk("R3 page write acks", int'(allAck), 1);
    waitReady(polls);
    rdRand(16'h007F, d); chk("R5 last offset", int'(d), 8'hA7);
    rdRand(16'h0000, d); chk("R5 wrapped to offset 0", int'(d), 8'hA8);
    rdRand(16'h0003, d); chk("R5 wrapped to offset 3", int'(d), 8'hAB);
    rdRand(16'h0080, d); chk("R5 next page untouched", int'(d), 8'h33);
    rdRand(16'h0005, d); chk("R5 unwritten offset kept", int'(d), 8'h22);

    // R6: write protect keeps data, no busy period
    wrProtect = 1'b1;
    wrSeq(16'h0005, 1, 8'hEE, allAck);
    probe(k);
    chk("R6 no busy when protected", int'(k), 1);
    wrProtect = 1'b0;
    rdRand(16'h0005, d);
    chk("R6 data unchanged", int'(d), 8'h22);

    // R10: START before STOP discards the write
    busStart(); sendByte(DEV_W, k); sendByte(8'h00, k); sendByte(8'h10, k);
    sendByte(8'h99, k);
    busStart(); busStop();
    probe(k);
    chk("R10 no busy after abort", int'(k), 1);
    rdRand(16'h0010, d);
    chk("R10 data unchanged", int'(d), 8'h44);

    // R8: sequential read across the top of the array
    wrSeq(16'h03FE, 2, 8'hC0, allAck); waitReady(polls);
    wrSeq(16'h0000, 3, 8'hD0, allAck); waitReady(polls);
    busStart(); sendByte(DEV_W, k); sendByte(8'h03, k); sendByte(8'hFE, k);
    busStart(); sendByte(DEV_R, k);
    recvByte(d, 1'b1); chk("R8 seq byte 0", int'(d), 8'hC0);
    recvByte(d, 1'b1); chk("R8 seq byte 1", int'(d), 8'hC1);
    recvByte(d, 1'b1); chk("R8 seq wrap to 0", int'(d), 8'hD0);
    recvByte(d, 1'b0); chk("R8 seq byte 3", int'(d), 8'hD1);
    busStop();

    // R9: current-address read continues at the next byte
    busStart(); sendByte(DEV_R, k); recvByte(d, 1'b0); busStop();
    chk("R9 current address read", int'(d), 8'hD2);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule